// File: doc/BRIEF.md
# QVGA LCD Sync Timing Generator

This block produces the raster timing for a 320x240 TFT panel that is fed over a parallel pixel bus. A horizontal clock counter and a line counter run on the bus clock and are decoded into active-low horizontal and vertical sync pulses, a data-enable strobe, and pixel, beat and line indices. An external pixel source uses these indices to place data on the bus. The bus may carry one pixel in one, two or three clocks, and the counter lengths scale with that setting.

The first valid data beat sits a fixed number of pixel times after the start of the horizontal sync. A further correction of a few clocks is added, chosen by the clocks-per-pixel setting, to cover the pipeline of the external packing logic. The four blanking lines are streamed like active lines, so data-enable is asserted on every line of the frame. An enable input starts and stops the raster. Dropping it parks both counters at the top of a frame, and raising it again starts a new frame with a full vertical sync.

Top module: `lcd_sync_gen`

## Requirements
- R1: While reset is high, and in the first output cycle after reset, hsync_n and vsync_n are 1 and de and frame_start are 0.
- R2: With enable held high, successive falling edges of hsync_n are exactly TOTAL_PIX*CPP clocks apart (336*CPP by default).
- R3: hsync_n is 0 for the first HS_PIX*CPP clocks of every line (2*CPP by default) and 1 for the rest of the line.
- R4: de is 1 for exactly ACT_PIX*CPP consecutive clocks per line. It starts LEAD_PIX*CPP + C clocks after the line start, where C is 0, 3 or 5 for CPP of 1, 2 or 3 (LEAD_PIX is 7 by default).
- R5: While de is 1, with k the number of clocks since de rose in that line, pix_idx equals floor(k/CPP) and beat equals k mod CPP. Both are 0 while de is 0.
- R6: A frame has ACT_LINES+BLANK_LINES lines (244 by default), and de is asserted on every one of them. line_idx counts 0 upward, one step per line, and wraps to 0. frame_start pulses repeat every TOTAL_PIX*CPP*(ACT_LINES+BLANK_LINES) clocks.
- R7: vsync_n is 0 only on line 0, during its first VS_PIX*CPP clocks, which coincide with the start of that line's hsync pulse.
- R8: frame_start is high for exactly one clock: the first clock of each vsync pulse (line 0, clock 0).
- R9: One clock after enable is sampled low, hsync_n and vsync_n are 1 and de and frame_start are 0. The first output cycle after enable returns is line 0, clock 0, with frame_start high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low parks the raster at frame start |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data-enable / line-valid strobe |
| frame_start | output | 1 | One-clock pulse at the first clock of vsync |
| pix_idx | output | $clog2(ACT_PIX) | Pixel index within the line while de is high |
| beat | output | beat_w(CPP) | Bus beat within the current pixel |
| line_idx | output | $clog2(ACT_LINES+BLANK_LINES) | Line index within the frame |

## Verification
The bench builds the block with CPP = 2 and shrinks the frame to 6 active plus 4 blanking lines, keeping the full 336-pixel line. CPP = 2 brings a non-zero pipeline correction of 3 clocks into the data-enable window. It also makes the beat index toggle inside each pixel. The short frame lets many frame wraps, line-counter rollovers and enable drops land at random raster positions within the run. The full-length line keeps the horizontal window exactly as it is on the real panel.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;

    // Internal sync flags, active high; the top inverts the syncs.
    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
        logic fs;
    } lcd_sync_t;

    // Extra clocks before the first data beat, covering the external packer.
    function automatic int pipe_fix(input int cpp);
        case (cpp)
            2:       return 3;
            3:       return 5;
            default: return 0;
        endcase
    endfunction

    function automatic int beat_w(input int cpp);
        return (cpp > 1) ? $clog2(cpp) : 1;
    endfunction

endpackage

// File: rtl/lcd_tg_hcount.sv
module lcd_tg_hcount #(
    parameter int TOTAL = 336,
    parameter int HW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    output logic [HW-1:0] h,
    output logic          eol
);
    localparam logic [HW-1:0] LAST = HW'(TOTAL - 1);

    assign eol = run && (h == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            h <= '0;
        end else if (h == LAST) begin
            h <= '0;
        end else begin
            h <= h + 1'b1;
        end
    end

    AST_H_RANGE:   assert property (@(posedge clk) disable iff (rst) h <= LAST); // R2
    AST_H_ADVANCE: assert property (@(posedge clk) disable iff (rst)
                       (run && h != LAST) |=> (h == $past(h) + HW'(1))); // R2
    AST_H_WRAP:    assert property (@(posedge clk) disable iff (rst)
                       (run && h == LAST) |=> (h == '0)); // R2
endmodule

// File: rtl/lcd_tg_vcount.sv
module lcd_tg_vcount #(
    parameter int LINES = 244,
    parameter int VW    = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          step,
    output logic [VW-1:0] v
);
    localparam logic [VW-1:0] LAST = VW'(LINES - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            v <= '0;
        end else if (step) begin
            v <= (v == LAST) ? '0 : v + 1'b1;
        end
    end

    AST_V_RANGE: assert property (@(posedge clk) disable iff (rst) v <= LAST); // R6
    AST_V_HOLD:  assert property (@(posedge clk) disable iff (rst)
                     (run && !step) |=> (v == $past(v))); // R6
endmodule

// File: rtl/lcd_tg_decode.sv
module lcd_tg_decode
    import lcd_tg_pkg::*;
#(
    parameter int CPP      = 1,
    parameter int ACT_PIX  = 320,
    parameter int HS_PIX   = 2,
    parameter int LEAD_PIX = 7,
    parameter int VS_PIX   = 2,
    parameter int HW       = 9,
    parameter int VW       = 8,
    parameter int PW       = 9,
    parameter int BW       = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] v,
    output lcd_sync_t     sync,
    output logic [PW-1:0] pix,
    output logic [BW-1:0] beat,
    output logic [VW-1:0] line
);
    localparam int HST    = LEAD_PIX * CPP + pipe_fix(CPP);
    localparam int HEND   = HST + ACT_PIX * CPP;
    localparam int HS_END = HS_PIX * CPP;
    localparam int VS_END = VS_PIX * CPP;

    lcd_sync_t     nxt;
    logic [HW-1:0] off;
    logic [PW-1:0] pix_n;
    logic [BW-1:0] beat_n;

    assign off = h - HW'(HST);

    always_comb begin
        nxt.hs = ({1'b0, h} < (HW+1)'(HS_END));
        nxt.vs = (v == '0) && ({1'b0, h} < (HW+1)'(VS_END));
        nxt.de = ({1'b0, h} >= (HW+1)'(HST)) && ({1'b0, h} < (HW+1)'(HEND));
        nxt.fs = (v == '0) && (h == '0);
    end

    generate
        if (CPP == 1) begin : g_direct
            assign pix_n  = PW'(off);
            assign beat_n = '0;
        end else begin : g_split
            assign pix_n  = PW'(off / HW'(CPP));
            assign beat_n = BW'(off % HW'(CPP));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sync <= '0;
            pix  <= '0;
            beat <= '0;
            line <= '0;
        end else begin
            sync <= nxt;
            pix  <= nxt.de ? pix_n  : '0;
            beat <= nxt.de ? beat_n : '0;
            line <= v;
        end
    end

    AST_DE_CLEAR_OF_HS:  assert property (@(posedge clk) disable iff (rst) sync.de |-> !sync.hs); // R4
    AST_PIX_RANGE:       assert property (@(posedge clk) disable iff (rst)
                             sync.de |-> ({1'b0, pix} < (PW+1)'(ACT_PIX))); // R5
    AST_VS_INSIDE_HS:    assert property (@(posedge clk) disable iff (rst) sync.vs |-> sync.hs); // R7
    AST_FS_STARTS_VS:    assert property (@(posedge clk) disable iff (rst) sync.fs |-> sync.vs); // R8
    AST_FS_SINGLE:       assert property (@(posedge clk) disable iff (rst) sync.fs |=> !sync.fs); // R8
    AST_IDLE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
                             !$past(run) |-> (sync == '0)); // R9
endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_tg_pkg::*;
#(
    parameter int CPP         = 1,
    parameter int ACT_PIX     = 320,
    parameter int TOTAL_PIX   = 336,
    parameter int HS_PIX      = 2,
    parameter int LEAD_PIX    = 7,
    parameter int ACT_LINES   = 240,
    parameter int BLANK_LINES = 4,
    parameter int VS_PIX      = 2
) (
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic                                     en,
    output logic                                     hsync_n,
    output logic                                     vsync_n,
    output logic                                     de,
    output logic                                     frame_start,
    output logic [$clog2(ACT_PIX)-1:0]               pix_idx,
    output logic [beat_w(CPP)-1:0]                   beat,
    output logic [$clog2(ACT_LINES+BLANK_LINES)-1:0] line_idx
);
    localparam int LINE_CLKS = TOTAL_PIX * CPP;
    localparam int LINES     = ACT_LINES + BLANK_LINES;
    localparam int HW        = $clog2(LINE_CLKS);
    localparam int VW        = $clog2(LINES);
    localparam int PW        = $clog2(ACT_PIX);
    localparam int BW        = beat_w(CPP);

    logic [HW-1:0] h;
    logic [VW-1:0] v;
    logic          eol;
    lcd_sync_t     sync;

    lcd_tg_hcount #(.TOTAL(LINE_CLKS), .HW(HW)) u_hcnt (
        .clk(clk), .rst(rst), .run(en), .h(h), .eol(eol)
    );

    lcd_tg_vcount #(.LINES(LINES), .VW(VW)) u_vcnt (
        .clk(clk), .rst(rst), .run(en), .step(eol), .v(v)
    );

    lcd_tg_decode #(
        .CPP(CPP), .ACT_PIX(ACT_PIX), .HS_PIX(HS_PIX), .LEAD_PIX(LEAD_PIX),
        .VS_PIX(VS_PIX), .HW(HW), .VW(VW), .PW(PW), .BW(BW)
    ) u_dec (
        .clk(clk), .rst(rst), .run(en), .h(h), .v(v),
        .sync(sync), .pix(pix_idx), .beat(beat), .line(line_idx)
    );

    assign hsync_n     = !sync.hs;
    assign vsync_n     = !sync.vs;
    assign de          = sync.de;
    assign frame_start = sync.fs;
endmodule

// File: tb/lcd_sync_gen_tb_top.sv
module lcd_sync_gen_tb_top;
    localparam int CPP         = 2;
    localparam int ACT_PIX     = 320;
    localparam int TOTAL_PIX   = 336;
    localparam int ACT_LINES   = 6;
    localparam int BLANK_LINES = 4;
    localparam int FIX   = (CPP == 1) ? 0 : (CPP == 2) ? 3 : 5;
    localparam int HPER  = TOTAL_PIX * CPP;
    localparam int LINES = ACT_LINES + BLANK_LINES;
    localparam int HST   = 7 * CPP + FIX;
    localparam int HACT  = ACT_PIX * CPP;
    localparam int PULSE = 2 * CPP;
    localparam int PW    = $clog2(ACT_PIX);
    localparam int BW    = (CPP > 1) ? $clog2(CPP) : 1;
    localparam int LW    = $clog2(LINES);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          hsync_n, vsync_n, de, frame_start;
    logic [PW-1:0] pix_idx;
    logic [BW-1:0] beat;
    logic [LW-1:0] line_idx;

    always #10 clk = ~clk;

    lcd_sync_gen #(
        .CPP(CPP), .ACT_PIX(ACT_PIX), .TOTAL_PIX(TOTAL_PIX),
        .ACT_LINES(ACT_LINES), .BLANK_LINES(BLANK_LINES)
    ) dut_i (
        .clk(clk), .rst(rst), .en(en), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .de(de), .frame_start(frame_start), .pix_idx(pix_idx), .beat(beat),
        .line_idx(line_idx)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit checking = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Raster position the outputs should show, derived from the requirements.
    int rh = 0, rv = 0, mh = 0, mv = 0;
    bit midle = 1, mrst = 1;

    always @(posedge clk) begin
        if (rst || !en) begin
            midle <= 1;
            mrst  <= rst;
            rh    <= 0;
            rv    <= 0;
        end else begin
            midle <= 0;
            mh    <= rh;
            mv    <= rv;
            if (rh == HPER - 1) begin
                rh <= 0;
                rv <= (rv == LINES - 1) ? 0 : rv + 1;
            end else begin
                rh <= rh + 1;
            end
        end
    end

    function automatic bit exp_de(input int h);
        return (h >= HST) && (h < HST + HACT);
    endfunction

    int  hgap = 0, fgap = 0;
    bit  hhave = 0, fhave = 0, prev_hs = 1;

    always @(negedge clk) begin
        if (checking) begin
            if (midle) begin
                chk(mrst ? "R1 hsync_n" : "R9 hsync_n", 32'(hsync_n), 1);
                chk(mrst ? "R1 vsync_n" : "R9 vsync_n", 32'(vsync_n), 1);
                chk(mrst ? "R1 de" : "R9 de", 32'(de), 0);
                chk(mrst ? "R1 frame_start" : "R9 frame_start", 32'(frame_start), 0);
                hhave = 0;
                fhave = 0;
            end else begin
                chk("R3 hsync_n", 32'(hsync_n), (mh < PULSE) ? 0 : 1);
                chk("R7 vsync_n", 32'(vsync_n), (mv == 0 && mh < PULSE) ? 0 : 1);
                chk("R4 de", 32'(de), 32'(exp_de(mh)));
                chk("R5 pix_idx", 32'(pix_idx), exp_de(mh) ? (mh - HST) / CPP : 0);
                chk("R5 beat", 32'(beat), exp_de(mh) ? (mh - HST) % CPP : 0);
                chk("R6 line_idx", 32'(line_idx), mv);
                chk("R8 frame_start", 32'(frame_start), (mh == 0 && mv == 0) ? 1 : 0);
                hgap++;
                fgap++;
                if (prev_hs && !hsync_n) begin
                    if (hhave) chk("R2 hsync period", hgap, HPER);
                    hgap  = 0;
                    hhave = 1;
                end
                if (frame_start) begin
                    if (fhave) chk("R6 frame period", fgap, HPER * LINES);
                    fgap  = 0;
                    fhave = 1;
                end
            end
            prev_hs = hsync_n;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240);
        rst = 1'b1;
        en  = 1'b0;
        repeat (4) @(negedge clk);
        checking = 1;
        repeat (3) @(negedge clk);
        en = 1'b1;                      // R1: enable during reset has no effect
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2 * HPER * LINES + 50) @(negedge clk);
        // R9: single-cycle stop in mid-line
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (HPER + 17) @(negedge clk);
        // random stop/start points
        for (int i = 0; i < 40; i++) begin
            repeat ($urandom_range(1, 2500)) @(negedge clk);
            en = 1'b0;
            repeat ($urandom_range(1, 6)) @(negedge clk);
            en = 1'b1;
        end
        // R1: reset in the middle of a frame
        repeat (333) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R9: stop on the last clock of a frame
        while (frame_start !== 1'b1) @(negedge clk);
        repeat (HPER * LINES - 1) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        en = 1'b1;
        repeat (HPER * LINES + 20) @(negedge clk);
        checking = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: all requirements, actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule